// File: doc/BRIEF.md
# Bus Access Address Fault Checker

This block watches every bus request issued by the processor core or the DMA engine and decides, before the access is allowed to complete, whether that request breaks an addressing rule. Each request carries an address, an access size, a flag that marks an instruction fetch, the identity of the requesting master and the level of the single-chip mode strap. The address is sorted into one of four spaces: peripheral space with an 8-bit port, peripheral space with a 16-bit port, external space, or on-chip memory. All region bounds are parameters.

The decision depends on several inputs together: the alignment of the address for the access size, the space the address falls in, the port width of a peripheral region, whether the request is a fetch, and whether the device runs in single-chip mode. The result is registered. A fault flag and a cause code show the verdict on the most recent request. A one-cycle abort pulse lets the bus logic suppress the write strobe of a faulting cycle. When more than one rule is broken, a fixed priority chooses the cause that is reported.

Top module: `addr_fault_checker`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `fault_flag`, `fault_cause` and `abort_pulse` are all zero.
- R2: A fetch from an odd address reports cause 1. A fetch from an even address in on-chip memory or external space (not in single-chip mode) reports no fault (cause 0).
- R3: A fetch whose address lies in either peripheral region reports cause 2, whatever its size or alignment.
- R4: With `single_chip` high, any request (fetch or data, any size) whose address lies in external space reports cause 3. With `single_chip` low, the same request is not faulted for that reason.
- R5: Size codes are 00 byte, 01 word, and 10 or 11 longword. A data word access with address bit 0 set, or a data longword access with address bits 1:0 non-zero, reports cause 4. Byte data accesses are never misaligned.
- R6: In peripheral space, aligned byte and word data accesses are legal. An aligned longword data access to the 16-bit region is legal. An aligned longword data access to the 8-bit region reports cause 5.
- R7: Data requests from the CPU (`req_master` 0) and the DMA engine (`req_master` 1) are judged by the same rules. A request from the DMA engine is always judged as data, even if `req_fetch` is set.
- R8: When several causes apply, the reported cause is the first of 3, 2, 1, 4, 5 in that order.
- R9: `fault_flag` and `fault_cause` change only in the cycle after a valid request and then show the verdict on that request. With `req_valid` low they hold their value. `fault_flag` is high exactly when `fault_cause` is non-zero.
- R10: `abort_pulse` is high for exactly the one cycle after a faulting valid request and is low otherwise. Back-to-back faulting requests give one pulse per request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | 32 | Request address |
| req_size | input | 2 | Access size: 00 byte, 01 word, 1x longword |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_master | input | 1 | 0 = CPU, 1 = DMA engine |
| single_chip | input | 1 | Single-chip mode strap |
| fault_flag | output | 1 | Verdict on the last valid request: fault |
| fault_cause | output | 3 | Cause of the last verdict (0 = none) |
| abort_pulse | output | 1 | One-cycle abort for a faulting request |

## Verification
Two things can happen in the same cycle. A single request can break several rules at once, and the priority selector must pick one reason while the abort pulse fires. The bench builds such requests on purpose: an odd fetch into peripheral space, an odd fetch into external space in single-chip mode, and a misaligned longword into the 8-bit peripheral region. Each of these is judged against the cause order in R8. The bench also sends faulting requests back to back, and puts idle cycles after them, to show that each request gives its own abort pulse while the flag and cause hold through the idle gaps.

// File: rtl/addr_fault_pkg.sv
package addr_fault_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_LALT = 2'b11
  } acc_size_e;

  typedef enum logic [2:0] {
    CZ_NONE         = 3'd0,
    CZ_FETCH_ODD    = 3'd1,
    CZ_FETCH_PERIPH = 3'd2,
    CZ_EXT_SINGLE   = 3'd3,
    CZ_DATA_ALIGN   = 3'd4,
    CZ_WIDTH        = 3'd5
  } fault_cause_e;

  localparam int CAUSE_W     = 3;
  localparam int NUM_REASONS = 5;
  localparam int NUM_WINDOWS = 3;

  // reason vector index = priority rank (0 wins)
  localparam int RS_EXT_SINGLE   = 0;
  localparam int RS_FETCH_PERIPH = 1;
  localparam int RS_FETCH_ODD    = 2;
  localparam int RS_DATA_ALIGN   = 3;
  localparam int RS_WIDTH        = 4;

  typedef struct packed {
    logic per8;
    logic per16;
    logic ext;
  } region_hit_t;

  function automatic fault_cause_e rank_to_cause(input int rank);
    case (rank)
      RS_EXT_SINGLE:   return CZ_EXT_SINGLE;
      RS_FETCH_PERIPH: return CZ_FETCH_PERIPH;
      RS_FETCH_ODD:    return CZ_FETCH_ODD;
      RS_DATA_ALIGN:   return CZ_DATA_ALIGN;
      RS_WIDTH:        return CZ_WIDTH;
      default:         return CZ_NONE;
    endcase
  endfunction

endpackage

// File: rtl/addr_region_decode.sv
module addr_region_decode
  import addr_fault_pkg::*;
#(
  parameter int              AW     = 32,
  parameter logic [AW-1:0]   P8_LO  = 32'hFFFF_8000,
  parameter logic [AW-1:0]   P8_HI  = 32'hFFFF_BFFF,
  parameter logic [AW-1:0]   P16_LO = 32'hFFFF_C000,
  parameter logic [AW-1:0]   P16_HI = 32'hFFFF_FFFF,
  parameter logic [AW-1:0]   EXT_LO = 32'h0040_0000,
  parameter logic [AW-1:0]   EXT_HI = 32'hFFFE_FFFF
) (
  input  logic [AW-1:0] addr,
  output region_hit_t   hit
);

  localparam logic [NUM_WINDOWS*AW-1:0] LO_VEC = {EXT_LO, P16_LO, P8_LO};
  localparam logic [NUM_WINDOWS*AW-1:0] HI_VEC = {EXT_HI, P16_HI, P8_HI};

  logic [NUM_WINDOWS-1:0] raw_hit;

  generate
    for (genvar w = 0; w < NUM_WINDOWS; w++) begin : g_window
      localparam logic [AW-1:0] LO = LO_VEC[w*AW +: AW];
      localparam logic [AW-1:0] HI = HI_VEC[w*AW +: AW];
      assign raw_hit[w] = (addr >= LO) && (addr <= HI);
    end
  endgenerate

  // peripheral windows take precedence over a wider external window
  always_comb begin
    hit.per8  = raw_hit[0];
    hit.per16 = raw_hit[1] & ~raw_hit[0];
    hit.ext   = raw_hit[2] & ~raw_hit[1] & ~raw_hit[0];
  end

endmodule

// File: rtl/addr_rule_eval.sv
module addr_rule_eval
  import addr_fault_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         valid,
  input  region_hit_t  hit,
  input  logic [1:0]   addr_lo,
  input  acc_size_e    size,
  input  logic         fetch,
  input  logic         master_dma,
  input  logic         single_chip,
  output fault_cause_e cause
);

  logic                   is_fetch;
  logic                   is_long;
  logic [NUM_REASONS-1:0] reason;

  assign is_fetch = fetch & ~master_dma;
  assign is_long  = size[1];

  always_comb begin
    reason                  = '0;
    reason[RS_EXT_SINGLE]   = single_chip & hit.ext;
    reason[RS_FETCH_PERIPH] = is_fetch & (hit.per8 | hit.per16);
    reason[RS_FETCH_ODD]    = is_fetch & addr_lo[0];
    reason[RS_DATA_ALIGN]   = ~is_fetch &
                              ((size == SZ_WORD) ? addr_lo[0] :
                               is_long           ? |addr_lo   : 1'b0);
    reason[RS_WIDTH]        = ~is_fetch & is_long & hit.per8;
  end

  always_comb begin
    cause = CZ_NONE;
    for (int r = NUM_REASONS - 1; r >= 0; r--) begin
      if (reason[r]) cause = rank_to_cause(r);
    end
  end

  // R6: byte data in peripheral space is never faulted
  p_periph_byte_ok_r6: assert property (@(posedge clk) disable iff (rst)
    (valid && !is_fetch && size == SZ_BYTE && (hit.per8 || hit.per16))
      |-> (cause == CZ_NONE));

  // R8: single-chip external access outranks every other reason
  p_ext_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (valid && single_chip && hit.ext) |-> (cause == CZ_EXT_SINGLE));

endmodule

// File: rtl/addr_fault_reg.sv
module addr_fault_reg
  import addr_fault_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               valid,
  input  fault_cause_e       cause_in,
  output logic               fault_flag,
  output logic [CAUSE_W-1:0] fault_cause,
  output logic               abort_pulse
);

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_flag  <= 1'b0;
      fault_cause <= '0;
      abort_pulse <= 1'b0;
    end else begin
      abort_pulse <= valid && (cause_in != CZ_NONE);
      if (valid) begin
        fault_flag  <= (cause_in != CZ_NONE);
        fault_cause <= cause_in;
      end
    end
  end

  // R10: abort only accompanies a fault verdict
  p_abort_has_flag_r10: assert property (@(posedge clk) disable iff (rst)
    abort_pulse |-> fault_flag);

  // R10: a faulting request is followed by an abort
  p_abort_follows_r10: assert property (@(posedge clk) disable iff (rst)
    (valid && cause_in != CZ_NONE) |=> abort_pulse);

  // R9: flag and cause agree
  p_flag_matches_cause_r9: assert property (@(posedge clk) disable iff (rst)
    fault_flag == (fault_cause != '0));

  // R9: idle cycles leave the verdict unchanged
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !valid |=> ($stable(fault_flag) && $stable(fault_cause) && !abort_pulse));

endmodule

// File: rtl/addr_fault_checker.sv
module addr_fault_checker
  import addr_fault_pkg::*;
#(
  parameter int            AW     = 32,
  parameter logic [AW-1:0] P8_LO  = 32'hFFFF_8000,
  parameter logic [AW-1:0] P8_HI  = 32'hFFFF_BFFF,
  parameter logic [AW-1:0] P16_LO = 32'hFFFF_C000,
  parameter logic [AW-1:0] P16_HI = 32'hFFFF_FFFF,
  parameter logic [AW-1:0] EXT_LO = 32'h0040_0000,
  parameter logic [AW-1:0] EXT_HI = 32'hFFFE_FFFF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [AW-1:0]      req_addr,
  input  logic [1:0]         req_size,
  input  logic               req_fetch,
  input  logic               req_master,
  input  logic               single_chip,
  output logic               fault_flag,
  output logic [CAUSE_W-1:0] fault_cause,
  output logic               abort_pulse
);

  region_hit_t  hit;
  fault_cause_e cause_comb;

  addr_region_decode #(
    .AW(AW), .P8_LO(P8_LO), .P8_HI(P8_HI), .P16_LO(P16_LO),
    .P16_HI(P16_HI), .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)
  ) u_decode (
    .addr (req_addr),
    .hit  (hit)
  );

  addr_rule_eval u_rules (
    .clk         (clk),
    .rst         (rst),
    .valid       (req_valid),
    .hit         (hit),
    .addr_lo     (req_addr[1:0]),
    .size        (acc_size_e'(req_size)),
    .fetch       (req_fetch),
    .master_dma  (req_master),
    .single_chip (single_chip),
    .cause       (cause_comb)
  );

  addr_fault_reg u_reg (
    .clk         (clk),
    .rst         (rst),
    .valid       (req_valid),
    .cause_in    (cause_comb),
    .fault_flag  (fault_flag),
    .fault_cause (fault_cause),
    .abort_pulse (abort_pulse)
  );

  // R4: single-chip external request reports cause 3 next cycle
  p_ext_single_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && single_chip && hit.ext) |=> (fault_cause == 3'd3));

  // R2: even CPU fetch from on-chip memory is clean next cycle
  p_even_fetch_ok_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_fetch && !req_master && !req_addr[0] &&
     !hit.ext && !hit.per8 && !hit.per16) |=> !fault_flag);

endmodule

// File: tb/addr_fault_checker_bench.sv
module addr_fault_checker_bench;

  typedef struct {
    logic       flag;
    logic [2:0] cause;
    logic       abort;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_fetch = 1'b0;
  logic        req_master = 1'b0;
  logic        single_chip = 1'b0;
  logic        fault_flag;
  logic [2:0]  fault_cause;
  logic        abort_pulse;

  int   total = 0;
  int   bad = 0;
  bit   done = 0;
  exp_t q[$];
  logic hold_flag = 1'b0;
  logic [2:0] hold_cause = 3'd0;

  always #10 clk = ~clk;

  addr_fault_checker u_addr_fault_checker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_fetch(req_fetch), .req_master(req_master),
    .single_chip(single_chip), .fault_flag(fault_flag),
    .fault_cause(fault_cause), .abort_pulse(abort_pulse)
  );

  function automatic logic [2:0] model(input logic [31:0] a, input logic [1:0] sz,
                                       input logic f, input logic m, input logic sc);
    logic p8, p16, ext, fe, mis;
    p8  = (a >= 32'hFFFF_8000) && (a <= 32'hFFFF_BFFF);
    p16 = (a >= 32'hFFFF_C000);
    ext = (a >= 32'h0040_0000) && (a <= 32'hFFFE_FFFF) && !p8 && !p16;
    fe  = f && !m;
    mis = (sz == 2'b01) ? a[0] : (sz[1] ? (a[1:0] != 2'b00) : 1'b0);
    if (sc && ext)              return 3'd3;
    if (fe && (p8 || p16))      return 3'd2;
    if (fe && a[0])             return 3'd1;
    if (!fe && mis)             return 3'd4;
    if (!fe && sz[1] && p8)     return 3'd5;
    return 3'd0;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic send(input string tag, input logic [31:0] a, input logic [1:0] sz,
                      input logic f, input logic m, input logic sc);
    exp_t e;
    logic [2:0] c;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz;
    req_fetch = f; req_master = m; single_chip = sc;
    c = model(a, sz, f, m, sc);
    hold_flag = (c != 3'd0); hold_cause = c;
    e.flag = hold_flag; e.cause = c; e.abort = (c != 3'd0); e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      @(negedge clk);
      req_valid = 1'b0;
      req_addr = 32'hFFFF_8003; req_fetch = 1'b1; single_chip = 1'b1;
      e.flag = hold_flag; e.cause = hold_cause; e.abort = 1'b0; e.tag = tag;
      q.push_back(e);
    end
  endtask

  // monitor: compare one expected item per cycle, 5 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (!rst && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, "fault_flag", fault_flag, e.flag);
        check(e.tag, "fault_cause", fault_cause, e.cause);
        check(e.tag, "abort_pulse", abort_pulse, e.abort);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check("R1", "flag in reset", fault_flag, 0);
    check("R1", "cause in reset", fault_cause, 0);
    check("R1", "abort in reset", abort_pulse, 0);
    @(negedge clk);
    rst = 1'b0;
    idle("R1", 2);

    send("R2", 32'h0000_0100, 2'b01, 1, 0, 0);
    send("R2", 32'h0000_0101, 2'b01, 1, 0, 0);
    send("R2", 32'h0100_0000, 2'b01, 1, 0, 0);
    send("R3", 32'hFFFF_8000, 2'b01, 1, 0, 0);
    send("R3", 32'hFFFF_C002, 2'b10, 1, 0, 0);
    idle("R9", 2);
    send("R4", 32'h0040_0000, 2'b01, 1, 0, 1);
    send("R4", 32'h0100_0000, 2'b00, 0, 0, 1);
    send("R4", 32'h0100_0000, 2'b00, 0, 0, 0);
    send("R5", 32'h0000_1001, 2'b01, 0, 0, 0);
    send("R5", 32'h0000_1002, 2'b10, 0, 0, 0);
    send("R5", 32'h0000_1003, 2'b11, 0, 0, 0);
    send("R5", 32'h0000_1004, 2'b10, 0, 0, 0);
    send("R5", 32'h0000_1003, 2'b00, 0, 0, 0);
    send("R6", 32'hFFFF_8001, 2'b00, 0, 0, 0);
    send("R6", 32'hFFFF_8002, 2'b01, 0, 0, 0);
    send("R6", 32'hFFFF_C004, 2'b10, 0, 0, 0);
    send("R6", 32'hFFFF_8004, 2'b10, 0, 0, 0);
    idle("R10", 1);
    send("R7", 32'h0000_1002, 2'b10, 0, 1, 0);
    send("R7", 32'hFFFF_8004, 2'b10, 0, 1, 0);
    send("R7", 32'h0000_1003, 2'b00, 1, 1, 0);
    send("R7", 32'hFFFF_C002, 2'b01, 1, 1, 0);
    send("R8", 32'hFFFF_8001, 2'b01, 1, 0, 1);
    send("R8", 32'h0040_0001, 2'b01, 1, 0, 1);
    send("R8", 32'hFFFF_8002, 2'b10, 0, 0, 1);
    send("R8", 32'h0080_0003, 2'b10, 0, 1, 1);
    idle("R9", 3);
    send("R10", 32'h0000_0201, 2'b01, 1, 0, 0);
    idle("R10", 2);
    send("R9", 32'h0000_0200, 2'b01, 1, 0, 0);
    idle("R9", 2);
    repeat (3) @(negedge clk);
    check("R9", "scoreboard drained", q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule